// File: doc/BRIEF.md
# Register-Access Packet Responder

This block is the device-side engine that lets a node with no link controller and no processor expose a byte-wide register file to the bus. Register-access packets are always two 32-bit quadlets long. The engine takes each incoming packet, decides whether it is a read or write request aimed at this device, and carries out the access on its local register file. It then builds a response packet of the matching kind. A request can address the device in one of two ways: by its 6-bit node number, which gives a 12-bit register address, or by a 14-bit static label, which gives a 20-bit register address. The response always uses the same addressing form as the request it answers.

The engine can also speak without being asked. A trigger input queues an unsolicited read or write response for a chosen register. That response always carries the device label, so a listening controller can tell which device sent it. Responses leave through a two-quadlet valid/ready port. The output holds one response at a time, and a one-entry buffer absorbs a single request that arrives while the output is stalled. A local port lets the application read and write the same registers.

Top module: `phy_reg_responder`

## Requirements
- R1: After reset, tx_valid_o is low and every register reads 0x00 through the application port.
- R2: Packet layout. Quadlet 0 holds the type in [31:28] (1 read request, 2 read response, 3 write request, 4 write response), the addressing form in [27] (0 node, 1 label), the node number in [26:21] or the label in [26:13]. Quadlet 1 holds the register address in [31:20] (node form) or [31:12] (label form) and the data byte in [7:0]. All other bits of a response are zero, and those bits are ignored on receipt.
- R3: A node-form request is served only when its node field equals node_id_i. Otherwise it produces no response and writes nothing.
- R4: A label-form request is served only when its label field equals label_i. Otherwise it produces no response and writes nothing.
- R5: A served write request stores its data byte. It is answered in the same form, carrying the device's own node number or label, the address, and the stored byte. The response is valid in the cycle after the request is sampled, provided the output was free.
- R6: A served read request is answered with a read response in the same form, carrying the register byte as it stood before that clock edge.
- R7: A received packet with a type code other than 1 or 3 is dropped. This includes responses from other devices. It sends nothing and changes no register.
- R8: An address at or beyond the register-file depth reads as 0x00, and a write to it is discarded. A response is still sent, and its data byte is 0x00.
- R9: While tx_valid_o is high and tx_ready_i is low, tx_valid_o and both output quadlets stay unchanged. A packet leaves on a cycle where both are high.
- R10: A request that arrives while the output is stalled goes into a one-entry buffer. Any request that arrives while that buffer is occupied is dropped without touching any register.
- R11: A pulse on trig_i, when no unsolicited response is already pending, queues one label-form response. It is a write response if trig_write_i is 1 and a read response otherwise, for address trig_addr_i, and its data is the register byte in the cycle it is loaded. Triggers that arrive while one is pending are ignored, unless the pending one is being loaded in that same cycle.
- R12: When the output frees, a buffered request response goes first, then a newly accepted request response, and only then a pending unsolicited response.
- R13: app_rdata_o shows the byte at app_addr_i combinationally. An application write takes effect at the next edge. A packet write to the same register in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 6 | Configured node number |
| label_i | input | 14 | Configured device label |
| rx_valid_i | input | 1 | Received packet strobe |
| rx_q0_i | input | 32 | Received quadlet 0 |
| rx_q1_i | input | 32 | Received quadlet 1 |
| tx_valid_o | output | 1 | Response packet valid |
| tx_ready_i | input | 1 | Transmit side accepts the packet |
| tx_q0_o | output | 32 | Response quadlet 0 |
| tx_q1_o | output | 32 | Response quadlet 1 |
| trig_i | input | 1 | Unsolicited response trigger |
| trig_write_i | input | 1 | Unsolicited kind: 1 write response, 0 read response |
| trig_addr_i | input | 20 | Register address for the unsolicited response |
| app_we_i | input | 1 | Application write enable |
| app_addr_i | input | $clog2(DEPTH) | Application register address |
| app_wdata_i | input | 8 | Application write byte |
| app_rdata_o | output | 8 | Application read byte |

## Verification
The bench builds the responder with DEPTH set to 16. This puts out-of-range addresses within easy reach in both addressing forms, including node-form addresses just past the end and label-form addresses above 0xFFFF. It also lets the reset check sweep every register through the application port. Node number 0x15 and label 0x2A5C are used, so that mismatches of a single bit in either field can be tested. A randomised phase with random transmit backpressure then exercises the buffer, the trigger and the request priority against one another.

// File: rtl/prr_pkg.sv
package prr_pkg;
  localparam int NODE_W  = 6;
  localparam int LABEL_W = 14;
  localparam int NADDR_W = 12;
  localparam int LADDR_W = 20;

  typedef enum logic [3:0] {
    PT_RD_REQ = 4'h1,
    PT_RD_RSP = 4'h2,
    PT_WR_REQ = 4'h3,
    PT_WR_RSP = 4'h4
  } ptype_e;

  typedef struct packed {
    logic               label_mode;
    logic               is_wr;
    logic [LADDR_W-1:0] addr;
    logic [7:0]         data;
  } req_t;

  function automatic logic [63:0] build_rsp(
    input logic               label_mode,
    input logic               is_wr,
    input logic [NODE_W-1:0]  node,
    input logic [LABEL_W-1:0] label,
    input logic [LADDR_W-1:0] addr,
    input logic [7:0]         data
  );
    logic [31:0] q0;
    logic [31:0] q1;
    q0 = '0;
    q1 = '0;
    q0[31:28] = is_wr ? PT_WR_RSP : PT_RD_RSP;
    q0[27]    = label_mode;
    if (label_mode) begin
      q0[26:13] = label;
      q1[31:12] = addr;
    end else begin
      q0[26:21] = node;
      q1[31:20] = addr[NADDR_W-1:0];
    end
    q1[7:0] = data;
    return {q0, q1};
  endfunction
endpackage

// File: rtl/prr_decode.sv
module prr_decode
  import prr_pkg::*;
(
  input  logic               rx_valid_i,
  input  logic [31:0]        rx_q0_i,
  input  logic [31:0]        rx_q1_i,
  input  logic [NODE_W-1:0]  node_id_i,
  input  logic [LABEL_W-1:0] label_i,
  output logic               req_v_o,
  output req_t               req_o
);
  logic [3:0] typ;
  logic       lbl;
  logic       hit;
  logic       known;
  logic       unused_bits;

  assign typ   = rx_q0_i[31:28];
  assign lbl   = rx_q0_i[27];
  assign hit   = lbl ? (rx_q0_i[26:13] == label_i) : (rx_q0_i[26:21] == node_id_i);
  assign known = (typ == PT_RD_REQ) || (typ == PT_WR_REQ);

  assign req_v_o          = rx_valid_i && hit && known;
  assign req_o.label_mode = lbl;
  assign req_o.is_wr      = (typ == PT_WR_REQ);
  assign req_o.addr       = lbl ? rx_q1_i[31:12] : {8'h00, rx_q1_i[31:20]};
  assign req_o.data       = rx_q1_i[7:0];

  assign unused_bits = ^{rx_q0_i[12:0], rx_q1_i[11:8]};
endmodule

// File: rtl/prr_regfile.sv
module prr_regfile
  import prr_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_we_i,
  input  logic [AW-1:0]      pkt_addr_i,
  input  logic [7:0]         pkt_wdata_i,
  input  logic               app_we_i,
  input  logic [AW-1:0]      app_addr_i,
  input  logic [7:0]         app_wdata_i,
  input  logic [LADDR_W-1:0] rd_addr_i,
  output logic [7:0]         rd_data_o,
  output logic [7:0]         app_rdata_o
);
  localparam logic [LADDR_W-1:0] LIMIT = LADDR_W'(DEPTH);

  logic [DEPTH-1:0][7:0] regs_q;
  logic [DEPTH-1:0][7:0] regs_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic pkt_hit;
    logic app_hit;
    assign pkt_hit   = pkt_we_i && (pkt_addr_i == AW'(i));
    assign app_hit   = app_we_i && (app_addr_i == AW'(i));
    assign regs_d[i] = pkt_hit ? pkt_wdata_i :
                       app_hit ? app_wdata_i : regs_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else         regs_q <= regs_d;
  end

  assign rd_data_o   = (rd_addr_i < LIMIT) ? regs_q[rd_addr_i[AW-1:0]] : 8'h00;
  assign app_rdata_o = regs_q[app_addr_i];
endmodule

// File: rtl/prr_tx_slot.sv
module prr_tx_slot (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_v_i,
  input  logic [63:0] req_pkt_i,
  input  logic        unsol_v_i,
  input  logic [63:0] unsol_pkt_i,
  input  logic        tx_ready_i,
  output logic        tx_valid_o,
  output logic [63:0] tx_pkt_o,
  output logic        buf_full_o,
  output logic        unsol_take_o
);
  logic        out_v_q;
  logic [63:0] out_q;
  logic        buf_v_q;
  logic [63:0] buf_q;
  logic        free;

  assign free         = !out_v_q || tx_ready_i;
  assign unsol_take_o = free && !buf_v_q && !req_v_i && unsol_v_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      out_q   <= '0;
      buf_v_q <= 1'b0;
      buf_q   <= '0;
    end else if (free) begin
      // order: buffered, fresh request, unsolicited
      if (buf_v_q) begin
        out_v_q <= 1'b1;
        out_q   <= buf_q;
        buf_v_q <= 1'b0;
      end else if (req_v_i) begin
        out_v_q <= 1'b1;
        out_q   <= req_pkt_i;
      end else if (unsol_v_i) begin
        out_v_q <= 1'b1;
        out_q   <= unsol_pkt_i;
      end else begin
        out_v_q <= 1'b0;
      end
    end else if (req_v_i) begin
      buf_v_q <= 1'b1;
      buf_q   <= req_pkt_i;
    end
  end

  assign tx_valid_o = out_v_q;
  assign tx_pkt_o   = out_q;
  assign buf_full_o = buf_v_q;
endmodule

// File: rtl/phy_reg_responder.sv
module phy_reg_responder
  import prr_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NODE_W-1:0]  node_id_i,
  input  logic [LABEL_W-1:0] label_i,
  input  logic               rx_valid_i,
  input  logic [31:0]        rx_q0_i,
  input  logic [31:0]        rx_q1_i,
  output logic               tx_valid_o,
  input  logic               tx_ready_i,
  output logic [31:0]        tx_q0_o,
  output logic [31:0]        tx_q1_o,
  input  logic               trig_i,
  input  logic               trig_write_i,
  input  logic [LADDR_W-1:0] trig_addr_i,
  input  logic               app_we_i,
  input  logic [AW-1:0]      app_addr_i,
  input  logic [7:0]         app_wdata_i,
  output logic [7:0]         app_rdata_o
);
  localparam logic [LADDR_W-1:0] LIMIT = LADDR_W'(DEPTH);

  logic               dec_v;
  req_t               dec_req;
  logic [LADDR_W-1:0] req_addr;
  logic               buf_full;
  logic               req_acc;
  logic               req_in_range;
  logic               pkt_we;
  logic [LADDR_W-1:0] rd_addr;
  logic [7:0]         rd_data;
  logic [7:0]         rsp_data;
  logic [63:0]        req_pkt;
  logic [63:0]        unsol_pkt;
  logic               unsol_take;
  logic               unsol_pend_q;
  logic               unsol_wr_q;
  logic [LADDR_W-1:0] unsol_addr_q;
  logic [63:0]        tx_pkt;

  prr_decode u_dec (
    .rx_valid_i (rx_valid_i),
    .rx_q0_i    (rx_q0_i),
    .rx_q1_i    (rx_q1_i),
    .node_id_i  (node_id_i),
    .label_i    (label_i),
    .req_v_o    (dec_v),
    .req_o      (dec_req)
  );

  assign req_addr     = dec_req.addr;
  assign req_acc      = dec_v && !buf_full;
  assign req_in_range = req_addr < LIMIT;
  assign pkt_we       = req_acc && dec_req.is_wr && req_in_range;
  // read port is shared; unsolicited loads only when no request is accepted
  assign rd_addr      = req_acc ? req_addr : unsol_addr_q;

  prr_regfile #(.DEPTH(DEPTH)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pkt_we_i    (pkt_we),
    .pkt_addr_i  (req_addr[AW-1:0]),
    .pkt_wdata_i (dec_req.data),
    .app_we_i    (app_we_i),
    .app_addr_i  (app_addr_i),
    .app_wdata_i (app_wdata_i),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .app_rdata_o (app_rdata_o)
  );

  assign rsp_data  = dec_req.is_wr ? (req_in_range ? dec_req.data : 8'h00) : rd_data;
  assign req_pkt   = build_rsp(dec_req.label_mode, dec_req.is_wr, node_id_i, label_i,
                               req_addr, rsp_data);
  assign unsol_pkt = build_rsp(1'b1, unsol_wr_q, node_id_i, label_i, unsol_addr_q, rd_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unsol_pend_q <= 1'b0;
      unsol_wr_q   <= 1'b0;
      unsol_addr_q <= '0;
    end else if (trig_i && (!unsol_pend_q || unsol_take)) begin
      unsol_pend_q <= 1'b1;
      unsol_wr_q   <= trig_write_i;
      unsol_addr_q <= trig_addr_i;
    end else if (unsol_take) begin
      unsol_pend_q <= 1'b0;
    end
  end

  prr_tx_slot u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_v_i      (req_acc),
    .req_pkt_i    (req_pkt),
    .unsol_v_i    (unsol_pend_q),
    .unsol_pkt_i  (unsol_pkt),
    .tx_ready_i   (tx_ready_i),
    .tx_valid_o   (tx_valid_o),
    .tx_pkt_o     (tx_pkt),
    .buf_full_o   (buf_full),
    .unsol_take_o (unsol_take)
  );

  assign tx_q0_o = tx_pkt[63:32];
  assign tx_q1_o = tx_pkt[31:0];
endmodule

// File: rtl/prr_checker.sv
module prr_checker #(
  parameter int DEPTH = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic [31:0] tx_q0_o,
  input logic [31:0] tx_q1_o,
  input logic [31:0] rx_q0_i,
  input logic [5:0]  node_id_i,
  input logic [13:0] label_i,
  input logic        buf_full,
  input logic        req_acc,
  input logic        pkt_we,
  input logic [19:0] req_addr,
  input logic        unsol_take
);
  localparam logic [19:0] LIMIT = 20'(DEPTH);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_q0_o) && $stable(tx_q1_o));

  // R2
  rsp_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_q0_o[31:28] == 4'h2) || (tx_q0_o[31:28] == 4'h4));

  // R3
  node_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_acc && !rx_q0_i[27] |-> rx_q0_i[26:21] == node_id_i);

  // R4
  label_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_acc && rx_q0_i[27] |-> rx_q0_i[26:13] == label_i);

  // R7
  req_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_acc |-> (rx_q0_i[31:28] == 4'h1) || (rx_q0_i[31:28] == 4'h3));

  // R8
  write_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_we |-> req_addr < LIMIT);

  // R10
  buf_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full |-> !req_acc && !pkt_we);

  // R12
  unsol_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsol_take |-> !req_acc && !buf_full);
endmodule

bind phy_reg_responder prr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_q0_o    (tx_q0_o),
  .tx_q1_o    (tx_q1_o),
  .rx_q0_i    (rx_q0_i),
  .node_id_i  (node_id_i),
  .label_i    (label_i),
  .buf_full   (buf_full),
  .req_acc    (req_acc),
  .pkt_we     (pkt_we),
  .req_addr   (req_addr),
  .unsol_take (unsol_take)
);

// File: tb/phy_reg_responder_tb_top.sv
module phy_reg_responder_tb_top;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [5:0]  NODE  = 6'h15;
  localparam logic [13:0] LABEL = 14'h2A5C;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  node_id = NODE;
  logic [13:0] label = LABEL;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_q0 = '0;
  logic [31:0] rx_q1 = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [31:0] tx_q0;
  logic [31:0] tx_q1;
  logic        trig = 1'b0;
  logic        trig_write = 1'b0;
  logic [19:0] trig_addr = '0;
  logic        app_we = 1'b0;
  logic [AW-1:0] app_addr = '0;
  logic [7:0]  app_wdata = '0;
  logic [7:0]  app_rdata;

  always #5 clk = ~clk;

  phy_reg_responder #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(node_id), .label_i(label),
    .rx_valid_i(rx_valid), .rx_q0_i(rx_q0), .rx_q1_i(rx_q1),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_q0_o(tx_q0), .tx_q1_o(tx_q1),
    .trig_i(trig), .trig_write_i(trig_write), .trig_addr_i(trig_addr),
    .app_we_i(app_we), .app_addr_i(app_addr), .app_wdata_i(app_wdata),
    .app_rdata_o(app_rdata)
  );

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [7:0]  m_mem [DEPTH];
  logic [63:0] m_q [$];
  bit          m_pend = 1'b0;
  bit          m_pwr = 1'b0;
  logic [19:0] m_paddr = '0;

  task automatic check(string t, string what, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  function automatic logic [63:0] mk_rsp(bit lbl, bit wr, logic [19:0] a, logic [7:0] d);
    logic [31:0] q0;
    logic [31:0] q1;
    q0 = '0; q1 = '0;
    q0[31:28] = wr ? 4'h4 : 4'h2;
    q0[27] = lbl;
    if (lbl) begin q0[26:13] = label; q1[31:12] = a; end
    else begin q0[26:21] = node_id; q1[31:20] = a[11:0]; end
    q1[7:0] = d;
    return {q0, q1};
  endfunction

  function automatic logic [7:0] rd_mem(logic [19:0] a);
    return (a < DEPTH) ? m_mem[a] : 8'h00;
  endfunction

  task automatic model_step();
    logic [3:0]  typ;
    bit          lbl, hit, isreq, acc, take, wr;
    logic [19:0] a;
    logic [63:0] pkt;
    logic [63:0] upkt;
    typ = rx_q0[31:28];
    lbl = rx_q0[27];
    hit = lbl ? (rx_q0[26:13] == label) : (rx_q0[26:21] == node_id);
    isreq = rx_valid && hit && (typ == 4'h1 || typ == 4'h3);
    wr = (typ == 4'h3);
    a = lbl ? rx_q1[31:12] : {8'h00, rx_q1[31:20]};
    acc = isreq && (m_q.size() < 2);
    pkt = mk_rsp(lbl, wr, a, wr ? ((a < DEPTH) ? rx_q1[7:0] : 8'h00) : rd_mem(a));
    upkt = mk_rsp(1'b1, m_pwr, m_paddr, rd_mem(m_paddr));
    if (m_q.size() > 0 && tx_ready) void'(m_q.pop_front());
    if (acc) m_q.push_back(pkt);
    take = !acc && (m_q.size() == 0) && m_pend;
    if (take) m_q.push_back(upkt);
    if (trig && (!m_pend || take)) begin
      m_pend = 1'b1; m_pwr = trig_write; m_paddr = trig_addr;
    end else if (take) m_pend = 1'b0;
    if (app_we) m_mem[app_addr] = app_wdata;
    if (acc && wr && a < DEPTH) m_mem[a] = rx_q1[7:0];
  endtask

  task automatic compare();
    check(tag, "tx_valid", 64'(tx_valid), 64'(m_q.size() != 0));
    if (m_q.size() != 0 && tx_valid) check(tag, "tx packet", {tx_q0, tx_q1}, m_q[0]);
    check(tag, "app_rdata", 64'(app_rdata), 64'(m_mem[app_addr]));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    rx_valid = 1'b0; trig = 1'b0; app_we = 1'b0;
  endtask

  task automatic send_node(logic [3:0] t, logic [5:0] n, logic [11:0] a, logic [7:0] d);
    rx_valid = 1'b1;
    rx_q0 = {t, 1'b0, n, 21'h0};
    rx_q1 = {a, 12'h0, d};
  endtask

  task automatic send_label(logic [3:0] t, logic [13:0] l, logic [19:0] a, logic [7:0] d);
    rx_valid = 1'b1;
    rx_q0 = {t, 1'b1, l, 13'h0};
    rx_q1 = {a, 4'h0, d};
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "tx_valid in reset", 64'(tx_valid), 64'd0);
    rst_ni = 1'b1;
    tag = "R1";
    for (int i = 0; i < DEPTH; i++) begin
      app_addr = AW'(i);
      #1;
      check("R1", "reset register", 64'(app_rdata), 64'h0);
      tick();
    end

    // R5: node write, hand-computed response
    tag = "R5";
    send_node(4'h3, NODE, 12'h003, 8'hA5);
    tick();
    check("R5", "write response", {tx_q0, tx_q1}, {32'h42A0_0000, 32'h0030_00A5});
    tick();

    // R6: node read
    tag = "R6";
    send_node(4'h1, NODE, 12'h003, 8'h00);
    tick();
    check("R6", "read response", {tx_q0, tx_q1}, {32'h22A0_0000, 32'h0030_00A5});
    tick();

    // R4: label write/read and mismatched label
    tag = "R4";
    send_label(4'h3, LABEL, 20'h00005, 8'h3C);
    tick();
    send_label(4'h1, LABEL, 20'h00005, 8'h00);
    tick();
    tick();
    check("R4", "label read response", {tx_q0, tx_q1}, {32'h2D4B_8000, 32'h0000_503C});
    send_label(4'h3, LABEL ^ 14'h0001, 20'h00006, 8'h77);
    tick();
    tick();
    app_addr = AW'(6);
    #1;
    check("R4", "mismatched label write", 64'(app_rdata), 64'h00);
    check("R4", "mismatched label no tx", 64'(tx_valid), 64'd0);

    // R3: mismatched node
    tag = "R3";
    send_node(4'h3, NODE ^ 6'h20, 12'h007, 8'h99);
    tick();
    app_addr = AW'(7);
    tick();
    check("R3", "mismatched node write", 64'(app_rdata), 64'h00);

    // R7: unknown type and foreign response
    tag = "R7";
    send_node(4'h7, NODE, 12'h007, 8'h55);
    tick();
    send_node(4'h4, NODE, 12'h007, 8'h66);
    tick();
    check("R7", "dropped type no tx", 64'(tx_valid), 64'd0);
    check("R7", "dropped type no write", 64'(app_rdata), 64'h00);

    // R8: out of range
    tag = "R8";
    send_node(4'h3, NODE, 12'h014, 8'hEE);
    tick();
    check("R8", "out-of-range write rsp", {tx_q0, tx_q1}, {32'h42A0_0000, 32'h0140_0000});
    send_label(4'h1, LABEL, 20'h10000, 8'h00);
    tick();
    tick();

    // R9/R10: stall, buffer, drop
    tag = "R10";
    tx_ready = 1'b0;
    send_node(4'h3, NODE, 12'h001, 8'h01);
    tick();
    send_node(4'h3, NODE, 12'h002, 8'h02);
    tick();
    send_node(4'h3, NODE, 12'h004, 8'h04);
    tick();
    tag = "R9";
    repeat (3) tick();
    tx_ready = 1'b1;
    repeat (3) tick();
    app_addr = AW'(4);
    #1;
    check("R10", "dropped request write", 64'(app_rdata), 64'h00);

    // R11/R12: unsolicited and priority
    tag = "R11";
    trig = 1'b1; trig_write = 1'b0; trig_addr = 20'h00003;
    tick();
    tick();
    check("R11", "unsolicited read rsp", {tx_q0, tx_q1}, {32'h2D4B_8000, 32'h0000_30A5});
    tick();
    tag = "R12";
    tx_ready = 1'b0;
    send_node(4'h1, NODE, 12'h001, 8'h00);
    tick();
    trig = 1'b1; trig_write = 1'b1; trig_addr = 20'h00002;
    tick();
    trig = 1'b1; trig_write = 1'b0; trig_addr = 20'h00009;
    send_label(4'h1, LABEL, 20'h00005, 8'h00);
    tick();
    tx_ready = 1'b1;
    tick();
    check("R12", "buffered before unsolicited", {tx_q0, tx_q1}, {32'h2D4B_8000, 32'h0000_503C});
    tick();
    check("R12", "unsolicited after requests", {tx_q0, tx_q1}, {32'h4D4B_8000, 32'h0000_2002});
    repeat (2) tick();

    // R13: application port and collision
    tag = "R13";
    app_we = 1'b1; app_addr = AW'(8); app_wdata = 8'h5A;
    tick();
    check("R13", "app write", 64'(app_rdata), 64'h5A);
    app_we = 1'b1; app_addr = AW'(8); app_wdata = 8'h11;
    send_node(4'h3, NODE, 12'h008, 8'h22);
    tick();
    check("R13", "packet wins collision", 64'(app_rdata), 64'h22);
    tick();

    // R2: random mix against the model
    tag = "R2";
    for (int c = 0; c < 600; c++) begin
      int r;
      logic [3:0] t;
      r = $urandom_range(0, 5);
      t = (r < 2) ? 4'h1 : (r < 4) ? 4'h3 : (r == 4) ? 4'h2 : 4'h9;
      tx_ready = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) != 0) begin
        if ($urandom_range(0, 1) == 1)
          send_node(t, ($urandom_range(0, 4) == 0) ? NODE ^ 6'h01 : NODE,
                    12'($urandom_range(0, 20)), 8'($urandom));
        else
          send_label(t, ($urandom_range(0, 4) == 0) ? LABEL ^ 14'h2000 : LABEL,
                     ($urandom_range(0, 7) == 0) ? 20'hF0000 : 20'($urandom_range(0, 18)),
                     8'($urandom));
      end
      if ($urandom_range(0, 9) == 0) begin
        trig = 1'b1; trig_write = 1'($urandom); trig_addr = 20'($urandom_range(0, 20));
      end
      if ($urandom_range(0, 9) == 0) begin
        app_we = 1'b1; app_wdata = 8'($urandom);
      end
      app_addr = AW'($urandom_range(0, DEPTH - 1));
      tick();
    end
    tx_ready = 1'b1;
    repeat (4) tick();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule